// File: doc/BRIEF.md
# Lockable Boot-Loaded Configuration Register

This block holds one 32-bit system configuration word and drives its fields as static controls for the rest of the chip. It comes out of system reset at a fixed value. While a boot window input is high, a single preload strobe may copy a flash configuration word into the register. The copy happens only when the flash read reported no failure and no blank/erased state. Some fields are never taken from flash: the lock field, the protection bits, the debug-port enable and the charge-pump override.

After boot, software writes through a plain write-enable/data port and reads the current value back. A two-bit lock field at bits 15:14 filters these writes. At 00 every writable field accepts data. At 10 the register is locked, but software can still reopen it. At 11 the register is locked until the next system reset. Bits 13:10 are protection bits that software can only set; only reset clears them. A write that the lock blocks raises a one-cycle flag.

The block also decodes the flash ECC mode field into two signals. It produces a trace-output enable that is gated by an external permission input.

Top module: `cfg_lock_reg`

## Requirements
- R1: On system reset (rst_n low), the register reads 0x7100000B, write_rejected is 0, and the preload opportunity is re-armed.
- R2: Bit 31 always reads 0, and writes to it have no effect.
- R3: A write with boot_window low updates bits 30:16 and 9:0 only when the lock field (bits 15:14) reads 00. Otherwise those bits keep their stored value.
- R4: A write with boot_window low may change the lock field only while it reads 00 or 10. Once it reads 11, only reset changes it.
- R5: A write that requests the reserved lock code 01 leaves the lock field at its old value. The stored lock field is never 01.
- R6: Bits 13:10 are set-only. While the lock field reads 00, a write ORs wr_data[13:10] into them. Writing 0 never clears them; only reset does.
- R7: A preload strobe during the boot window leaves the register unchanged if boot_fail or boot_blank is 1.
- R8: A trusted preload copies flash_word into bits 30:16, 9:5 and 2:0. Bits 15:10, 4 and 3 keep their values, and bit 31 stays 0.
- R9: Only the first preload strobe after reset is acted on, whether that strobe was trusted or not. Later strobes change nothing.
- R10: wr_en has no effect while boot_window is high.
- R11: trace_out_en equals bit 2 ANDed with trace_allow. It is 0 whenever trace_allow is 0.
- R12: Bits 29:28 decode as follows: 00 gives ecc_on=1 and dynamic_ecc=0; 01 gives ecc_on=1 and dynamic_ecc=1; 10 and 11 give ecc_on=0 and dynamic_ecc=0.
- R13: write_rejected is high for exactly the one cycle after a write with boot_window low that found the lock field not at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| boot_window | input | 1 | High during the pre-boot load period |
| preload_strobe | input | 1 | Single-cycle request to load flash_word |
| boot_fail | input | 1 | Flash configuration read reported a failure |
| boot_blank | input | 1 | Flash configuration word is blank/erased |
| flash_word | input | 32 | Configuration word read from flash |
| wr_en | input | 1 | Software write enable |
| wr_data | input | 32 | Software write data |
| trace_allow | input | 1 | External permission for trace output |
| rd_data | output | 32 | Current register value |
| trace_out_en | output | 1 | Gated trace-output enable |
| ecc_on | output | 1 | Flash ECC active (full or dynamic) |
| dynamic_ecc | output | 1 | Dynamic ECC mode selected |
| write_rejected | output | 1 | One-cycle pulse after a blocked write |

## Verification
The register value, ecc_on and dynamic_ecc follow from the clock edge that takes a write or preload. write_rejected is registered, so all of these are due one cycle after the stimulus edge. trace_out_en is combinational from the stored bit and trace_allow, so it is due in the same cycle once the stored bit has settled.

The driver stamps each expected item with its due cycle, counted from a free-running cycle counter. The monitor compares an item only in that cycle, shortly after the rising edge. Inputs change on the falling edge, so they are stable when the monitor samples.

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_window,
  input  logic        preload_strobe,
  input  logic        boot_fail,
  input  logic        boot_blank,
  input  logic [31:0] flash_word,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        trace_allow,
  output logic [31:0] rd_data,
  output logic        trace_out_en,
  output logic        ecc_on,
  output logic        dynamic_ecc,
  output logic        write_rejected
);

  localparam logic [31:0] RST_VAL = 32'h7100_000B;
  localparam logic [31:0] PROT_M  = 32'h0000_3C00;
  localparam logic [31:0] LOCK_M  = 32'h0000_C000;
  localparam logic [31:0] PLAIN_M = 32'h7FFF_03FF;
  localparam logic [31:0] KEEP_M  = 32'h0000_FC18;
  localparam logic [31:0] PRE_M   = ~KEEP_M & 32'h7FFF_FFFF;

  logic [31:0] cfg_q, cfg_d;
  logic        loaded_q;
  logic [1:0]  lock;
  logic        wr_go, pre_go, trusted, lock_ok;

  assign lock    = cfg_q[15:14];
  assign wr_go   = wr_en && !boot_window;
  assign pre_go  = preload_strobe && boot_window && !loaded_q;
  assign trusted = !boot_fail && !boot_blank;
  assign lock_ok = (lock != 2'b11) && (wr_data[15:14] != 2'b01);

  always_comb begin
    cfg_d = cfg_q;
    if (pre_go && trusted) begin
      cfg_d = (cfg_q & KEEP_M) | (flash_word & PRE_M);
    end else if (wr_go) begin
      if (lock == 2'b00)
        cfg_d = (cfg_d & ~PLAIN_M) | (wr_data & PLAIN_M) | (wr_data & PROT_M);
      if (lock_ok)
        cfg_d = (cfg_d & ~LOCK_M) | (wr_data & LOCK_M);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q          <= RST_VAL;
      loaded_q       <= 1'b0;
      write_rejected <= 1'b0;
    end else begin
      cfg_q          <= cfg_d;
      if (pre_go) loaded_q <= 1'b1;
      write_rejected <= wr_go && (lock != 2'b00);
    end
  end

  assign rd_data      = cfg_q;
  assign trace_out_en = cfg_q[2] & trace_allow;
  assign ecc_on       = ~cfg_q[29];
  assign dynamic_ecc  = (cfg_q[29:28] == 2'b01);

  a_r2_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31]);

  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !boot_window && rd_data[15:14] != 2'b00) |=>
      (rd_data[30:16] == $past(rd_data[30:16]) && rd_data[9:0] == $past(rd_data[9:0])));

  a_r4_hard_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:14] == 2'b11) |=> (rd_data[15:14] == 2'b11));

  a_r5_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:14] != 2'b01);

  a_r6_prot_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(rd_data[13:10]) & ~rd_data[13:10]) == 4'b0000));

  a_r7_untrusted_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_strobe && boot_window && (boot_fail || boot_blank)) |=> $stable(rd_data));

  a_r8_preload_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_strobe && boot_window) |=>
      (rd_data[15:10] == $past(rd_data[15:10]) && rd_data[4:3] == $past(rd_data[4:3])));

  a_r9_single_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && boot_window) |=> $stable(rd_data));

  a_r10_window_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_window && !preload_strobe) |=> $stable(rd_data));

  a_r11_trace_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_allow |-> !trace_out_en);

  a_r12_ecc_decode: assert property (@(posedge clk) disable iff (!rst_n)
    dynamic_ecc |-> ecc_on);

  a_r13_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
    write_rejected |-> $past(wr_en && !boot_window && rd_data[15:14] != 2'b00));

endmodule

// File: tb/cfg_lock_reg_bench.sv
module cfg_lock_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_window = 1'b0, preload_strobe = 1'b0, boot_fail = 1'b0, boot_blank = 1'b0;
  logic [31:0] flash_word = '0, wr_data = '0;
  logic        wr_en = 1'b0, trace_allow = 1'b0;
  logic [31:0] rd_data;
  logic        trace_out_en, ecc_on, dynamic_ecc, write_rejected;

  always #2.5 clk = ~clk;

  cfg_lock_reg u_cfg_lock_reg (
    .clk(clk), .rst_n(rst_n), .boot_window(boot_window), .preload_strobe(preload_strobe),
    .boot_fail(boot_fail), .boot_blank(boot_blank), .flash_word(flash_word),
    .wr_en(wr_en), .wr_data(wr_data), .trace_allow(trace_allow),
    .rd_data(rd_data), .trace_out_en(trace_out_en), .ecc_on(ecc_on),
    .dynamic_ecc(dynamic_ecc), .write_rejected(write_rejected));

  int checks = 0, errors = 0, cyc = 0;
  int q_cyc[$];
  logic [35:0] q_exp[$];
  string q_req[$];

  logic [31:0] m;
  logic        m_done;
  bit          drv_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [35:0] expect_of(logic [31:0] v, logic rej, logic tal);
    return {rej, ~v[29], (v[29:28] == 2'b01), v[2] & tal, v};
  endfunction

  task automatic step(input logic wr, input logic [31:0] d, input logic win, input logic stb,
                      input logic fl, input logic bl, input logic [31:0] fw, input logic tal,
                      input string req);
    logic rej;
    logic [1:0] lk;
    @(negedge clk);
    wr_en = wr; wr_data = d; boot_window = win; preload_strobe = stb;
    boot_fail = fl; boot_blank = bl; flash_word = fw; trace_allow = tal;
    rej = 1'b0;
    if (win && stb && !m_done) begin
      m_done = 1'b1;
      if (!fl && !bl) m = (m & 32'h0000_FC18) | (fw & 32'h7FFF_03E7);
    end else if (wr && !win) begin
      lk = m[15:14];
      if (lk == 2'b00) begin
        m[30:16] = d[30:16];
        m[9:0]   = d[9:0];
        m[13:10] = m[13:10] | d[13:10];
      end
      if (lk != 2'b11 && d[15:14] != 2'b01) m[15:14] = d[15:14];
      rej = (lk != 2'b00);
    end
    q_cyc.push_back(cyc + 1);
    q_exp.push_back(expect_of(m, rej, tal));
    q_req.push_back(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; preload_strobe = 1'b0; boot_window = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m = 32'h7100_000B; m_done = 1'b0;
  endtask

  always begin
    @(posedge clk); #1;
    while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
      logic [35:0] e, a;
      string r;
      e = q_exp.pop_front(); r = q_req.pop_front(); void'(q_cyc.pop_front());
      a = {write_rejected, ecc_on, dynamic_ecc, trace_out_en, rd_data};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s at cycle %0d: actual rej=%b ecc=%b dyn=%b tr=%b rd=%h expected rej=%b ecc=%b dyn=%b tr=%b rd=%h",
                 r, cyc, a[35], a[34], a[33], a[32], a[31:0], e[35], e[34], e[33], e[32], e[31:0]);
      end
    end
  end

  initial begin
    do_reset();
    step(0, 0, 0, 0, 0, 0, 0, 1, "R1 reset value");
    step(0, 0, 1, 1, 1, 0, 32'hFFFF_FFFF, 0, "R7 fail status keeps reset value");
    step(0, 0, 1, 1, 0, 0, 32'hFFFF_FFFF, 0, "R9 second strobe ignored");
    do_reset();
    step(0, 0, 1, 1, 0, 1, 32'hFFFF_FFFF, 0, "R7 blank word keeps reset value");
    do_reset();
    step(1, 32'h0000_0000, 1, 0, 0, 0, 0, 0, "R10 write in boot window ignored");
    step(0, 0, 1, 1, 0, 0, 32'hFFFF_FFFF, 1, "R8 trusted preload of ones skips fields");
    step(0, 0, 1, 1, 0, 0, 32'h0000_0000, 1, "R9 later preload ignored");
    do_reset();
    step(0, 0, 1, 1, 0, 0, 32'h0000_0000, 0, "R8 trusted preload of zeros, R12 full ecc");
    step(1, 32'h9123_0004, 0, 0, 0, 0, 0, 0, "R2 R3 R12 unlocked write, dynamic ecc, trace gated R11");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R11 trace allowed");
    step(1, 32'h2000_2404, 0, 0, 0, 0, 0, 1, "R6 set protection bits, R12 disabled ecc");
    step(1, 32'h0000_0000, 0, 0, 0, 0, 0, 1, "R6 zero write keeps protection bits");
    step(1, 32'h0000_4001, 0, 0, 0, 0, 0, 0, "R5 reserved lock code refused");
    step(1, 32'h8000_8000, 0, 0, 0, 0, 0, 0, "R4 soft lock");
    step(1, 32'h0000_8005, 0, 0, 0, 0, 0, 0, "R3 R13 soft lock blocks fields");
    step(1, 32'h0000_0000, 0, 0, 0, 0, 0, 0, "R4 soft lock reopened");
    step(1, 32'h0000_C000, 0, 0, 0, 0, 0, 0, "R4 hard lock");
    step(1, 32'h0000_0007, 0, 0, 0, 0, 0, 0, "R4 R13 hard lock refuses unlock");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R13 pulse is one cycle");
    do_reset();
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1 R6 reset clears lock and protection");
    repeat (3) @(negedge clk);
    drv_done = 1;
  end

  initial begin
    fork
      wait (drv_done);
      begin repeat (5000) @(posedge clk); checks++; errors++; $display("FAIL watchdog expired"); end
    join_any
    if (q_cyc.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_cyc.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule